// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of up to sixteen DMA channels may use the shared bus. Each channel holds a pending request line high for as long as it has elements left to move. The arbiter answers with a one-hot grant. The channel that holds the grant pulses a completion strobe for each single element it finishes. The address path, the data path, trigger selection and the bus protocol all sit outside this block. It produces only grants, a count of the elements moved in the current tenure, and the channel that currently heads the priority order.

Two global settings shape arbitration. The first picks fixed priority, where the lowest-numbered pending channel wins. The alternative is a rotating order, in which a channel that finishes its block falls to the back of the line. The second setting limits how long one channel may hold the bus. It can leave the tenure unlimited, or end it after 9, 17 or 32 elements, at which point arbitration runs again. Both settings are expected to stay constant while any channel is active. Their reset-time intent is unlimited tenure with fixed priority.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset, no grant is asserted, the element count is 0 and the priority head is channel 0. At no time is more than one grant bit high.
- R2: A grant goes only to a channel whose request was high in the cycle before. An idle arbiter that sees a request grants on the next clock edge with an element count of 0.
- R3: With the rotation setting at 0, the pending channel with the lowest index wins every arbitration.
- R4: With the rotation setting at 1, when the holder's request drops, the priority head becomes holder+1 (wrapping to 0 after the last channel). The next arbitration searches upward from that head, wrapping around.
- R5: The grant falls one cycle after the holder's request drops, and the element count returns to 0 at the same time.
- R6: The grant changes only on a cycle that carries an element-completion strobe, or on release. It never changes in the middle of an element.
- R7: Burst setting encoding: 0 means unlimited (the holder keeps the bus until its request drops), 1 means 9 elements, 2 means 17 and 3 means 32. When the limit is reached, arbitration runs again among all pending channels.
- R8: If the holder is still the highest-priority pending channel when its limit is reached, it keeps the grant and its element count reloads to 0.
- R9: The element count rises by one for each completion strobe received while a grant is held. A strobe that arrives while no grant is held is ignored.
- R10: The priority-head output reads 0 whenever the rotation setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel pending request |
| elem_done_i | input | 1 | Holder finished one element this cycle |
| burst_sel_i | input | 2 | Tenure limit: 0 unlimited, 1 nine, 2 seventeen, 3 thirty-two |
| rr_en_i | input | 1 | 1 selects rotating priority, 0 selects fixed |
| gnt_o | output | NUM_CH | One-hot grant |
| burst_cnt_o | output | CNT_W | Elements moved in the current tenure |
| prio_top_o | output | $clog2(NUM_CH) | Channel at the head of the priority order |

## Verification
The bench aims at the limits that are not powers of two. It drives a lower-priority holder through exactly limit-1 elements and then through one more element. An arbiter that uses 8, 16 or 33 as the limit, or that compares against the wrong count value, hands the bus over a cycle early or late. A second test lets the holder itself win again at expiry and checks that its count restarts rather than runs on. A third test has a channel finish and then request again under rotation. Here an arbiter that fails to move the head to holder+1, or that fails to wrap, would regrant the channel that just finished. Completion strobes sent while the arbiter is idle confirm that the count does not creep upward.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        TENURE_UNLIM = 2'd0,
        TENURE_9     = 2'd1,
        TENURE_17    = 2'd2,
        TENURE_32    = 2'd3
    } tenure_e;

    // Number of elements after which the holder is re-arbitrated; 0 = never.
    function automatic int unsigned tenure_limit(input logic [1:0] sel);
        case (sel)
            2'd1:    return 9;
            2'd2:    return 17;
            2'd3:    return 32;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dma_arb_pick.sv
// Rotating priority search: first requester at or above 'top', wrapping.
module dma_arb_pick #(
    parameter int unsigned NUM_CH = 16,
    localparam int unsigned IW    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [IW-1:0]     top_i,
    output logic              valid_o,
    output logic [IW-1:0]     idx_o
);

    always_comb begin
        int unsigned pos;
        valid_o = 1'b0;
        idx_o   = '0;
        // Walk from the lowest priority slot upward so the highest one wins last.
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            pos = 32'(top_i) + 32'(k);
            if (pos >= NUM_CH) begin
                pos = pos - NUM_CH;
            end
            if (req_i[pos]) begin
                valid_o = 1'b1;
                idx_o   = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/dma_arb_tenure.sv
// Decodes the tenure setting and flags when a count reaches its limit.
module dma_arb_tenure #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expire_o
);

    import dma_arb_pkg::*;

    logic [CNT_W-1:0] limit;

    always_comb begin
        limit    = CNT_W'(tenure_limit(sel_i));
        expire_o = (limit != '0) && (count_i == limit);
    end

endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned IW    = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              elem_done_i,
    input  logic [1:0]        burst_sel_i,
    input  logic              rr_en_i,
    output logic [NUM_CH-1:0] gnt_o,
    output logic [CNT_W-1:0]  burst_cnt_o,
    output logic [IW-1:0]     prio_top_o
);

    typedef struct packed {
        logic              busy;
        logic [IW-1:0]     owner;
        logic [CNT_W-1:0]  cnt;
        logic [IW-1:0]     top;
        logic [NUM_CH-1:0] gnt;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [IW-1:0]    search_top;
    logic             pick_valid;
    logic [IW-1:0]    pick_idx;
    logic [CNT_W-1:0] cnt_inc;
    logic             expire;

    assign search_top = rr_en_i ? st_q.top : '0;
    assign cnt_inc    = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + CNT_W'(1);

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i   (req_i),
        .top_i   (search_top),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    dma_arb_tenure #(.CNT_W(CNT_W)) u_tenure (
        .sel_i    (burst_sel_i),
        .count_i  (cnt_inc),
        .expire_o (expire)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (!req_i[st_q.owner]) begin
                // Holder finished its block: release, rotate if enabled.
                st_d.busy = 1'b0;
                st_d.gnt  = '0;
                st_d.cnt  = '0;
                if (rr_en_i) begin
                    if (32'(st_q.owner) == NUM_CH - 1) begin
                        st_d.top = '0;
                    end else begin
                        st_d.top = st_q.owner + IW'(1);
                    end
                end
            end else if (elem_done_i) begin
                if (expire) begin
                    st_d.cnt = '0;
                    if (pick_valid) begin
                        st_d.owner = pick_idx;
                        st_d.gnt   = {{(NUM_CH-1){1'b0}}, 1'b1} << pick_idx;
                    end
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end else if (pick_valid) begin
            st_d.busy  = 1'b1;
            st_d.owner = pick_idx;
            st_d.cnt   = '0;
            st_d.gnt   = {{(NUM_CH-1){1'b0}}, 1'b1} << pick_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.gnt;
    assign burst_cnt_o = st_q.cnt;
    assign prio_top_o  = rr_en_i ? st_q.top : '0;

endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned IW    = $clog2(NUM_CH)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] req_i,
    input logic              elem_done_i,
    input logic [1:0]        burst_sel_i,
    input logic              rr_en_i,
    input logic [NUM_CH-1:0] gnt_o,
    input logic [CNT_W-1:0]  burst_cnt_o,
    input logic [IW-1:0]     prio_top_o
);

    import dma_arb_pkg::*;

    AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o)); // R1

    AST_GNT_WAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|gnt_o) |-> ((gnt_o & $past(req_i)) != '0)); // R2

    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|gnt_o) && ((gnt_o & req_i) == '0)) |=> (gnt_o == '0 && burst_cnt_o == '0)); // R5

    AST_HOLD_MID_ELEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((gnt_o & req_i) != '0) && !elem_done_i) |=> $stable(gnt_o)); // R6

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_sel_i != 2'd0) |-> (32'(burst_cnt_o) < tenure_limit(burst_sel_i))); // R7

    AST_TOP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rr_en_i |-> (prio_top_o == '0)); // R10

endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .elem_done_i (elem_done_i),
    .burst_sel_i (burst_sel_i),
    .rr_en_i     (rr_en_i),
    .gnt_o       (gnt_o),
    .burst_cnt_o (burst_cnt_o),
    .prio_top_o  (prio_top_o)
);

// File: tb/tb_dma_chan_arb.sv
`timescale 1ns/1ps
module tb_dma_chan_arb;

    localparam int unsigned N  = 16;
    localparam int unsigned CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          done = 1'b0;
    logic [1:0]    bsel = 2'd0;
    logic          rr = 1'b0;
    logic [N-1:0]  gnt;
    logic [CW-1:0] cnt;
    logic [3:0]    top;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_chan_arb #(.NUM_CH(N), .CNT_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .elem_done_i(done),
        .burst_sel_i(bsel), .rr_en_i(rr),
        .gnt_o(gnt), .burst_cnt_o(cnt), .prio_top_o(top)
    );

    // {req[16], done, expected grant[16], expected count[8]}, fixed priority, unlimited
    localparam logic [40:0] VEC [13] = '{
        {16'h0000, 1'b0, 16'h0000, 8'd0},
        {16'h0006, 1'b0, 16'h0002, 8'd0},
        {16'h0007, 1'b1, 16'h0002, 8'd1},
        {16'h0007, 1'b1, 16'h0002, 8'd2},
        {16'h0005, 1'b0, 16'h0000, 8'd0},
        {16'h0005, 1'b0, 16'h0001, 8'd0},
        {16'h0005, 1'b1, 16'h0001, 8'd1},
        {16'h0004, 1'b0, 16'h0000, 8'd0},
        {16'h0004, 1'b1, 16'h0004, 8'd0},
        {16'h8004, 1'b0, 16'h0004, 8'd0},
        {16'h8000, 1'b0, 16'h0000, 8'd0},
        {16'h8000, 1'b0, 16'h8000, 8'd0},
        {16'h0000, 1'b0, 16'h0000, 8'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic d);
        @(negedge clk);
        req  = r;
        done = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        done  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Holder ch1 is pushed out by pending ch0 after exactly lim elements.
    task automatic run_tenure(input logic [1:0] sel, input int lim, input string tag);
        do_reset();
        bsel = sel;
        step(16'h0002, 1'b0);
        check({tag, " grant ch1"}, 32'(gnt), 32'h2);
        for (int i = 0; i < lim - 1; i++) step(16'h0003, 1'b1);
        check({tag, " holder before limit"}, 32'(gnt), 32'h2);
        check({tag, " count before limit"}, 32'(cnt), 32'(lim - 1));
        step(16'h0003, 1'b1);
        check({tag, " preempted at limit"}, 32'(gnt), 32'h1);
        check({tag, " count reload"}, 32'(cnt), 32'h0);
        step(16'h0000, 1'b0);
        bsel = 2'd0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R1 reset grant", 32'(gnt), 32'h0);
        check("R1 reset count", 32'(cnt), 32'h0);
        check("R1 reset top", 32'(top), 32'h0);

        // R2 R3 R5 R9: fixed priority table
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][40:25], VEC[i][24]);
            check($sformatf("R3 vec%0d grant", i), 32'(gnt), 32'(VEC[i][23:8]));
            check($sformatf("R9 vec%0d count", i), 32'(cnt), 32'(VEC[i][7:0]));
        end

        // R7: the three limits
        run_tenure(2'd1, 9,  "R7 nine");
        run_tenure(2'd2, 17, "R7 seventeen");
        run_tenure(2'd3, 32, "R7 thirty-two");

        // R7 unlimited: holder keeps the bus
        do_reset();
        bsel = 2'd0;
        step(16'h0002, 1'b0);
        for (int i = 0; i < 40; i++) step(16'h0003, 1'b1);
        check("R7 unlimited holder", 32'(gnt), 32'h2);
        check("R7 unlimited count", 32'(cnt), 32'd40);
        step(16'h0000, 1'b0);
        check("R5 release", 32'(gnt), 32'h0);

        // R8: holder still highest, regranted with count reload
        do_reset();
        bsel = 2'd1;
        step(16'h0001, 1'b0);
        for (int i = 0; i < 8; i++) step(16'h0003, 1'b1);
        check("R8 count 8", 32'(cnt), 32'd8);
        step(16'h0003, 1'b1);
        check("R8 regrant", 32'(gnt), 32'h1);
        check("R8 count reload", 32'(cnt), 32'h0);
        step(16'h0000, 1'b0);
        bsel = 2'd0;

        // R4: rotation
        do_reset();
        rr = 1'b1;
        step(16'h0005, 1'b0);
        check("R4 first grant ch0", 32'(gnt), 32'h1);
        step(16'h0004, 1'b0);
        check("R4 release", 32'(gnt), 32'h0);
        check("R4 head after ch0", 32'(top), 32'h1);
        step(16'h0005, 1'b0);
        check("R4 ch2 beats ch0", 32'(gnt), 32'h4);
        step(16'h0001, 1'b0);
        check("R4 head after ch2", 32'(top), 32'h3);
        step(16'h0001, 1'b0);
        check("R4 wrap to ch0", 32'(gnt), 32'h1);
        step(16'h0000, 1'b0);
        step(16'h8000, 1'b0);
        check("R4 grant ch15", 32'(gnt), 32'h8000);
        step(16'h0000, 1'b0);
        check("R4 head wraps", 32'(top), 32'h0);
        step(16'h0000, 1'b0);
        step(16'h0004, 1'b0);
        step(16'h0000, 1'b0);
        check("R4 head after ch2 again", 32'(top), 32'h3);
        @(negedge clk);
        rr = 1'b0;
        #1;
        check("R10 head hidden when fixed", 32'(top), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule